// File: doc/BRIEF.md
# Vector Element Sequencer

This block lives in the decode path of an out-of-order core. It takes in one instruction at a time over a valid/ready handshake. Each instruction carries three register specifiers (a destination and two sources), a vector length, an opcode, and a flag that marks it as vector or scalar. A vector instruction is split into a run of scalar micro-operations, one per active element. The block emits them one per cycle. In each replica the register fields are rewritten so that they name a single element in a flat 256-entry architectural register space.

In the flat space, the index of element `e` of vector register `v` is `v*8 + e`. The 64 scalar registers share storage with vector registers 0 to 7, so scalar register `r` has the flat index `r`. The second source can be marked as a scalar operand. It then names the same register in every replica. Every micro-op carries its element index and flags that mark the first and the last op of its group. Downstream logic treats the micro-ops as plain scalar instructions.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `outValid` is low and `inReady` is high.
- R2: A vector instruction with length L from 1 to 8 produces exactly L micro-ops, with element indices 0 to L-1 in order. A length of 0 produces 8.
- R3: A vector length greater than 8 is clamped, so the instruction produces 8 micro-ops.
- R4: For a vector instruction, the destination and first source of micro-op e read `{spec[4:0], e[2:0]}`. The index therefore rises by exactly one from each replica to the next.
- R5: When `inSrcBScalar` is set on a vector instruction, every replica carries `outSrcB` as the zero-extended 6-bit `inSrcB`, unchanged. When the flag is clear, `outSrcB` follows the R4 rule.
- R6: A scalar instruction (`inVec` low) produces one micro-op. Its three fields are the zero-extended 6-bit specifiers, its element index is 0, both `outFirst` and `outLast` are set, and `inVlen` has no effect.
- R7: While a group is in flight, `inReady` is low and `inValid` is ignored. A new instruction is accepted only once the last micro-op of the group has been taken.
- R8: While `outValid` is high and `outReady` is low, all output fields stay stable and `outValid` stays high.
- R9: `outFirst` is set only on element 0, and `outLast` only on the final micro-op of a group. One cycle after the last handshake, `outValid` is low.
- R10: `outOp` carries the accepted opcode unchanged on every micro-op of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An instruction is offered |
| inReady | output | 1 | The block can accept an instruction |
| inVec | input | 1 | 1 = vector instruction, 0 = scalar |
| inOp | input | 8 | Opcode, passed through |
| inDst | input | 6 | Destination specifier: vector register in bits 4:0, or scalar register |
| inSrcA | input | 6 | First source specifier |
| inSrcB | input | 6 | Second source specifier |
| inSrcBScalar | input | 1 | The second source is a scalar operand that is not stepped |
| inVlen | input | 4 | Vector length (0 means 8, values above 8 are clamped) |
| outValid | output | 1 | A micro-op is presented |
| outReady | input | 1 | Downstream takes the micro-op |
| outOp | output | 8 | Micro-op opcode |
| outDst | output | 8 | Flat destination index |
| outSrcA | output | 8 | Flat first-source index |
| outSrcB | output | 8 | Flat second-source index |
| outElem | output | 3 | Element index of this micro-op |
| outFirst | output | 1 | First micro-op of the group |
| outLast | output | 1 | Last micro-op of the group |

## Verification
A wrong element counter shows up at once as a flat index off by some multiple of one on the first micro-op after it goes wrong. It also shows up as a group that is too long or too short, which appears as a missing or extra `outLast` within at most eight cycles. A busy flag stuck high leaves `inReady` low after the group ends, which the next scenario exposes. A busy flag that clears early lets an intruding instruction replace the fields in the middle of a group, and the next micro-op reveals it. Handshakes with stalls confirm that a low `outReady` freezes both the counter and the fields.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int ELEMS  = 8;
  localparam int ELEMW  = $clog2(ELEMS);
  localparam int VREGS  = 32;
  localparam int VREGW  = $clog2(VREGS);
  localparam int FLATW  = VREGW + ELEMW;
  localparam int SREGW  = 6;
  localparam int VLENW  = ELEMW + 1;
  localparam int NOPS   = 3;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       isLast,
  output logic       inReady,
  output logic       outValid,
  output seqStrobe_t strobe
);
  logic busy;

  always_comb begin
    strobe.load = inValid && !busy;
    strobe.step = busy && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else if (strobe.load) busy <= 1'b1;
    else if (strobe.step && isLast) busy <= 1'b0;
  end

  assign inReady  = !busy;
  assign outValid = busy;

  // R7: the group stays in flight until its last op is taken
  a_r7_stay_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(outReady && isLast) |=> busy && !inReady);
endmodule

// File: rtl/vseq_dp.sv
module vseq_dp
  import vseq_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             inVec,
  input  logic [OPW-1:0]   inOp,
  input  logic [SREGW-1:0] inDst,
  input  logic [SREGW-1:0] inSrcA,
  input  logic [SREGW-1:0] inSrcB,
  input  logic             inSrcBScalar,
  input  logic [VLENW-1:0] inVlen,
  output logic             isLast,
  output logic [OPW-1:0]   outOp,
  output logic [FLATW-1:0] outDst,
  output logic [FLATW-1:0] outSrcA,
  output logic [FLATW-1:0] outSrcB,
  output logic [ELEMW-1:0] outElem,
  output logic             outFirst,
  output logic             outLast
);
  logic             capVec;
  logic [OPW-1:0]   capOp;
  logic [SREGW-1:0] capReg  [NOPS];
  logic [NOPS-1:0]  capHold;
  logic [ELEMW-1:0] capLast;
  logic [ELEMW-1:0] elem;
  logic [ELEMW-1:0] effLast;
  logic [FLATW-1:0] flat    [NOPS];

  // last element index derived from the requested length
  always_comb begin
    if (!inVec)
      effLast = '0;
    else if (inVlen == '0 || inVlen >= VLENW'(ELEMS))
      effLast = ELEMW'(ELEMS - 1);
    else
      effLast = ELEMW'(inVlen - VLENW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVec  <= 1'b0;
      capOp   <= '0;
      capHold <= '0;
      capLast <= '0;
      elem    <= '0;
      for (int i = 0; i < NOPS; i++) capReg[i] <= '0;
    end else if (strobe.load) begin
      capVec    <= inVec;
      capOp     <= inOp;
      capHold   <= {inSrcBScalar, 2'b00};
      capLast   <= effLast;
      elem      <= '0;
      capReg[0] <= inDst;
      capReg[1] <= inSrcA;
      capReg[2] <= inSrcB;
    end else if (strobe.step && !isLast) begin
      elem <= elem + 1'b1;
    end
  end

  // one index builder per operand slot
  for (genvar g = 0; g < NOPS; g++) begin : g_flat
    always_comb begin
      if (capVec && !capHold[g])
        flat[g] = {capReg[g][VREGW-1:0], elem};
      else
        flat[g] = FLATW'(capReg[g]);
    end
  end

  assign isLast   = (elem == capLast);
  assign outOp    = capOp;
  assign outDst   = flat[0];
  assign outSrcA  = flat[1];
  assign outSrcB  = flat[2];
  assign outElem  = elem;
  assign outFirst = (elem == '0);
  assign outLast  = isLast;

  // R4: consecutive replicas step the destination by one
  a_r4_dst_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !isLast |=> outDst == FLATW'($past(outDst) + FLATW'(1)));

  // R5: a scalar operand source is held across replicas
  a_r5_hold_scalar_src: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !isLast && capHold[2] |=> outSrcB == $past(outSrcB));
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inVec,
  input  logic [OPW-1:0]   inOp,
  input  logic [SREGW-1:0] inDst,
  input  logic [SREGW-1:0] inSrcA,
  input  logic [SREGW-1:0] inSrcB,
  input  logic             inSrcBScalar,
  input  logic [VLENW-1:0] inVlen,
  output logic             outValid,
  input  logic             outReady,
  output logic [OPW-1:0]   outOp,
  output logic [FLATW-1:0] outDst,
  output logic [FLATW-1:0] outSrcA,
  output logic [FLATW-1:0] outSrcB,
  output logic [ELEMW-1:0] outElem,
  output logic             outFirst,
  output logic             outLast
);
  seqStrobe_t strobe;
  logic       isLast;

  vseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .isLast(isLast), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  vseq_dp #(.OPW(OPW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inVec(inVec), .inOp(inOp),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inSrcBScalar(inSrcBScalar), .inVlen(inVlen), .isLast(isLast),
    .outOp(outOp), .outDst(outDst), .outSrcA(outSrcA), .outSrcB(outSrcB),
    .outElem(outElem), .outFirst(outFirst), .outLast(outLast)
  );

  // R8: a stalled micro-op is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outDst) && $stable(outSrcA)
      && $stable(outSrcB) && $stable(outElem) && $stable(outOp));

  // R9: the group ends right after its last op is taken
  a_r9_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid);
endmodule

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       inVec = 1'b0;
  logic [7:0] inOp = '0;
  logic [5:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic       inSrcBScalar = 1'b0;
  logic [3:0] inVlen = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] outOp, outDst, outSrcA, outSrcB;
  logic [2:0] outElem;
  logic       outFirst, outLast;

  int nCmp = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  vec_elem_seq i_vec_elem_seq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inVec(inVec), .inOp(inOp), .inDst(inDst), .inSrcA(inSrcA),
    .inSrcB(inSrcB), .inSrcBScalar(inSrcBScalar), .inVlen(inVlen),
    .outValid(outValid), .outReady(outReady), .outOp(outOp),
    .outDst(outDst), .outSrcA(outSrcA), .outSrcB(outSrcB),
    .outElem(outElem), .outFirst(outFirst), .outLast(outLast)
  );

  task automatic check(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flatOf(bit vec, bit hold, logic [5:0] r, int e);
    if (vec && !hold) return {r[4:0], 3'(e)};
    return {2'b00, r};
  endfunction

  // sends one instruction and checks every micro-op of its group
  task automatic runGroup(string tag, bit vec, logic [5:0] d, logic [5:0] a,
                          logic [5:0] b, bit bs, logic [3:0] vl, logic [7:0] op,
                          bit stall, bit intrude);
    int n;
    n = !vec ? 1 : ((vl == 0 || vl >= 8) ? 8 : int'(vl));
    @(negedge clk);
    check({tag, " R7 idle ready"}, inReady, 1);
    inValid = 1'b1; inVec = vec; inDst = d; inSrcA = a; inSrcB = b;
    inSrcBScalar = bs; inVlen = vl; inOp = op;
    @(posedge clk);
    #1 inValid = 1'b0;
    for (int e = 0; e < n; e++) begin
      @(negedge clk);
      if (intrude && e == 1) begin
        inValid = 1'b1; inVec = 1'b0; inDst = 6'd63; inSrcA = 6'd62;
        inSrcB = 6'd61; inOp = 8'hEE;
      end
      if (intrude && e == n - 1) inValid = 1'b0;
      check({tag, " R8 valid"}, outValid, 1);
      check({tag, " R7 busy"}, inReady, 0);
      check({tag, " R2 elem"}, outElem, vec ? e : 0);
      check({tag, " R4 dst"}, outDst, flatOf(vec, 0, d, e));
      check({tag, " R4 srcA"}, outSrcA, flatOf(vec, 0, a, e));
      check({tag, " R5 srcB"}, outSrcB, flatOf(vec, bs, b, e));
      check({tag, " R10 op"}, outOp, op);
      check({tag, " R9 first"}, outFirst, e == 0);
      check({tag, " R9 last"}, outLast, e == n - 1);
      if (stall && e == 1) begin
        outReady = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R8 held valid"}, outValid, 1);
        check({tag, " R8 held elem"}, outElem, e);
        check({tag, " R8 held dst"}, outDst, flatOf(vec, 0, d, e));
        check({tag, " R8 held srcB"}, outSrcB, flatOf(vec, bs, b, e));
        outReady = 1'b1;
      end
    end
    @(negedge clk);
    check({tag, " R9 group ended"}, outValid, 0);
    check({tag, " R7 ready again"}, inReady, 1);
  endtask

  task automatic testReset();
    check("R1 outValid", outValid, 0);
    check("R1 inReady", inReady, 1);
  endtask

  task automatic testShortVector();
    runGroup("vl3", 1, 6'd5, 6'd9, 6'd20, 0, 4'd3, 8'h11, 0, 0);
  endtask

  task automatic testStallScalarOperand();
    runGroup("vl8 stall", 1, 6'd31, 6'd0, 6'd45, 1, 4'd8, 8'h22, 1, 1);
  endtask

  task automatic testZeroLength();
    runGroup("vl0 R2", 1, 6'd12, 6'd13, 6'd14, 0, 4'd0, 8'h33, 0, 0);
  endtask

  task automatic testClamp();
    runGroup("vl12 R3", 1, 6'd24, 6'd7, 6'd3, 1, 4'd12, 8'h44, 1, 0);
  endtask

  task automatic testScalar();
    runGroup("scalar R6", 0, 6'd63, 6'd17, 6'd40, 1, 4'd5, 8'h55, 0, 0);
  endtask

  task automatic testSingle();
    runGroup("vl1", 1, 6'd8, 6'd16, 6'd30, 0, 4'd1, 8'h66, 0, 0);
  endtask

  initial begin
    #2000000;
    nCmp++; nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShortVector();
    testStallScalarOperand();
    testZeroLength();
    testClamp();
    testScalar();
    testSingle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule